// File: doc/BRIEF.md
# Configurable SPI Master Word Shifter

This block is a single-channel SPI master that moves one word at a time over the serial pins. A one-entry holding register accepts the next transmit word. When the engine is idle and the current format is legal, it takes that word, shifts it out on MOSI with a generated serial clock and collects the same number of bits from MISO. It then places the received word in a one-entry receive buffer, along with a per-word parity-error indication.

The format word is read live from the `cfg_fmt` input and latched when a word starts. It selects the clock ratio, the character length, the clock idle level, the clock phase, the bit order, an optional parity bit and a gap between consecutive words. A loopback control feeds the engine's own MOSI back to its receive side. The two buffer flags appear in a 32-bit status word at fixed bit positions that software decodes.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the holding register is empty (status bit 29 = 0), the receive buffer is empty (status bit 31 = 1), every other status bit is 0, overrun is 0 and SCLK and MOSI are 0.
- R2: The prescale field `cfg_fmt[15:8]` gives a clock ratio R = prescale + 1. Each bit lasts R clock cycles, so leading SCLK edges are R cycles apart. A prescale below 2 is refused: the held word stays held and SCLK does not toggle.
- R3: The character length `cfg_fmt[4:0]` sets the number of data bits, with legal values 2 to 16. Any other length holds the word without starting. When `cfg_fmt[20]` = 1 the word goes out least-significant bit first; when it is 0 it goes out most-significant bit first.
- R4: `cfg_fmt[17]` is the SCLK idle level, and SCLK follows it while the engine is idle. When `cfg_fmt[16]` = 1, MOSI is valid before the first edge and bits are sampled on the leading (idle-to-active) edge. When it is 0, MOSI changes on the leading edge and bits are sampled on the trailing edge.
- R5: When `cfg_fmt[22]` = 1, one parity bit follows the data bits. It is odd parity when `cfg_fmt[23]` = 1 and even parity when it is 0. On receive, a mismatch sets `rx_par_err` for that word, and the data is still delivered.
- R6: `cfg_fmt[29:24]` holds a gap G in clock cycles. For back-to-back words of N bits (data plus parity), the first leading edges of the two words are N·R + G + 1 cycles apart.
- R7: A `tx_wr` is accepted only while status bit 29 is 0. A write while it is 1 is ignored, and the held word is not replaced.
- R8: Received data is right-justified in `rx_data`, with the bits above the character length at 0. `rx_rd` empties the buffer, so status bit 31 returns to 1.
- R9: A word that completes while the buffer is still full overwrites it and sets `rx_overrun`. A read clears `rx_overrun`.
- R10: With `cfg_loop` = 1, the receive side takes MOSI instead of the `miso` pin. With `cfg_loop` = 0, it takes `miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 32 | Format word |
| cfg_loop | input | 1 | Internal loopback select |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 16 | Word to transmit |
| rx_rd | input | 1 | Pops the receive buffer |
| stat | output | 32 | Status: bit 29 holding full, bit 31 receive empty |
| rx_data | output | 16 | Received word, right-justified |
| rx_par_err | output | 1 | Parity mismatch on the buffered word |
| rx_overrun | output | 1 | A word was overwritten before being read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions take for granted that `cfg_fmt` changes only while no word is being shifted. They also assume that `tx_wr` and `rx_rd` are single-cycle strobes sampled by the clock. Under those conditions the SCLK idle level, the holding-register and buffer flags, and the overrun flag follow from port activity alone. The stimulus holds to this by changing the format only after each received word has been read and the engine has settled. The refusal cases change the format while a word is held but before any clocking has started.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  localparam int LEN_W = 5;
  localparam int PRE_W = 8;
  localparam int GAP_W = 6;
  localparam int MAX_LEN = 16;
  localparam int MIN_LEN = 2;
  localparam int MIN_PRE = 2;

  localparam int STAT_TXF = 29;
  localparam int STAT_RXE = 31;

  typedef struct packed {
    logic [GAP_W-1:0] gap;
    logic             par_odd;
    logic             par_en;
    logic             lsb_first;
    logic             cpol;
    logic             pha_lead;
    logic [PRE_W-1:0] pre;
    logic [LEN_W-1:0] len;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [31:0] w);
    fmt_t f;
    f.gap       = w[29:24];
    f.par_odd   = w[23];
    f.par_en    = w[22];
    f.lsb_first = w[20];
    f.cpol      = w[17];
    f.pha_lead  = w[16];
    f.pre       = w[15:8];
    f.len       = w[4:0];
    return f;
  endfunction

  function automatic logic fmt_legal(input fmt_t f, input int max_len);
    return (int'(f.pre) >= MIN_PRE) && (int'(f.len) >= MIN_LEN) &&
           (int'(f.len) <= max_len);
  endfunction

endpackage

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             lead,
  output logic             trail,
  output logic             wrap
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W:0]   ratio;
  logic [PRE_W:0]   half;

  assign ratio = {1'b0, pre} + 1'b1;
  assign half  = ratio >> 1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == pre) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lead  = run && (cnt == '0);
  assign trail = run && ({1'b0, cnt} == half);
  assign wrap  = run && (cnt == pre);

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fmt_t              fmt_in,
  input  logic              idle_pol,
  input  logic [DATA_W-1:0] word_in,
  input  logic              rx_line,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_perr
);

  localparam int SEQ_W = DATA_W + 1;
  localparam int IDX_W = $clog2(SEQ_W + 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} est_t;

  est_t             st;
  fmt_t             f;
  logic [SEQ_W-1:0] tseq;
  logic [SEQ_W-1:0] rseq;
  logic [SEQ_W-1:0] seq_in;
  logic [IDX_W-1:0] bidx;
  logic [IDX_W-1:0] last_idx;
  logic [GAP_W-1:0] gcnt;
  logic             lead, trail, wrap;

  // Bits laid out in the order they leave the pin; parity after data.
  function automatic logic [SEQ_W-1:0] pack_seq(input logic [DATA_W-1:0] w,
                                                input fmt_t ff);
    logic [SEQ_W-1:0] s;
    logic p;
    s = '0;
    p = ff.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(ff.len)) begin
        s[i] = ff.lsb_first ? w[i] : w[int'(ff.len) - 1 - i];
        p    = p ^ w[i];
      end
    end
    if (ff.par_en) s[ff.len] = p;
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] unpack_seq(input logic [SEQ_W-1:0] r,
                                                   input fmt_t ff);
    logic [DATA_W-1:0] d;
    d = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(ff.len)) begin
        if (ff.lsb_first) d[i] = r[i];
        else              d[int'(ff.len) - 1 - i] = r[i];
      end
    end
    return d;
  endfunction

  assign seq_in  = pack_seq(word_in, fmt_in);
  assign rx_word = unpack_seq(rseq, f);
  assign rx_perr = f.par_en & ((^rx_word) ^ rseq[f.len] ^ f.par_odd);
  assign busy    = (st != E_IDLE);

  spi_sclk_timer #(.PRE_W(PRE_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (st == E_SHIFT),
    .pre   (f.pre),
    .lead  (lead),
    .trail (trail),
    .wrap  (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      f        <= '0;
      tseq     <= '0;
      rseq     <= '0;
      bidx     <= '0;
      last_idx <= '0;
      gcnt     <= '0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          sclk <= idle_pol;
          if (start) begin
            f        <= fmt_in;
            tseq     <= seq_in;
            bidx     <= '0;
            last_idx <= IDX_W'(int'(fmt_in.len) + int'(fmt_in.par_en) - 1);
            sclk     <= fmt_in.cpol;
            if (fmt_in.pha_lead) mosi <= seq_in[0];
            st       <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (lead) begin
            sclk <= ~f.cpol;
            if (f.pha_lead) rseq[bidx] <= rx_line;
            else            mosi       <= tseq[bidx];
          end
          if (trail) begin
            sclk <= f.cpol;
            if (f.pha_lead) begin
              if (bidx != last_idx) mosi <= tseq[bidx + 1'b1];
            end else begin
              rseq[bidx] <= rx_line;
            end
          end
          if (wrap) begin
            if (bidx == last_idx) begin
              done <= 1'b1;
              if (f.gap == '0) begin
                st <= E_IDLE;
              end else begin
                st   <= E_GAP;
                gcnt <= f.gap;
              end
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        E_GAP: begin
          gcnt <= gcnt - 1'b1;
          if (gcnt == GAP_W'(1)) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_rx_stage.sv
module spi_rx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wperr,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              full,
  output logic              overrun
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      perr    <= 1'b0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else if (wr) begin
      data <= wdata;
      perr <= wperr;
      full <= 1'b1;
      if (full && !rd) overrun <= 1'b1;
    end else if (rd) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_fmt,
  input  logic              cfg_loop,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [31:0]       stat,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_overrun,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  fmt_t              fmt_cur;
  logic              fmt_ok;
  logic              idle_pol;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              eng_done;
  logic [DATA_W-1:0] eng_word;
  logic              eng_perr;
  logic              rx_full;
  logic              rx_line;

  assign fmt_cur  = fmt_decode(cfg_fmt);
  assign fmt_ok   = fmt_legal(fmt_cur, DATA_W);
  assign idle_pol = fmt_cur.cpol;
  assign take     = hold_full && !busy && fmt_ok;
  assign rx_line  = cfg_loop ? mosi : miso;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (tx_wr && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
    end
  end

  spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (take),
    .fmt_in   (fmt_cur),
    .idle_pol (idle_pol),
    .word_in  (hold_data),
    .rx_line  (rx_line),
    .busy     (busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (eng_done),
    .rx_word  (eng_word),
    .rx_perr  (eng_perr)
  );

  spi_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .wr      (eng_done),
    .wdata   (eng_word),
    .wperr   (eng_perr),
    .rd      (rx_rd),
    .data    (rx_data),
    .perr    (rx_par_err),
    .full    (rx_full),
    .overrun (rx_overrun)
  );

  always_comb begin
    stat           = '0;
    stat[STAT_TXF] = hold_full;
    stat[STAT_RXE] = ~rx_full;
  end

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic clk,
  input logic rst,
  input logic rx_rd,
  input logic hold_full,
  input logic take,
  input logic busy,
  input logic fmt_ok,
  input logic rx_full,
  input logic eng_done,
  input logic rx_overrun,
  input logic sclk,
  input logic idle_pol
);

  // R2: an illegal format never releases a held word
  a_r2_refuse_illegal: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !fmt_ok) |=> hold_full);

  // R7: the holding register only empties when the engine takes it
  a_r7_hold_keep: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !take) |=> hold_full);

  // R8: a read with no arriving word leaves the buffer empty
  a_r8_read_empties: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !eng_done) |=> !rx_full);

  // R9: arrival into a full, unread buffer flags overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (eng_done && rx_full && !rx_rd) |=> rx_overrun);

  // R4: idle clock level follows the polarity bit
  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $past(!rst) && $stable(idle_pol)) |-> (sclk == idle_pol));

endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_rd      (rx_rd),
  .hold_full  (hold_full),
  .take       (take),
  .busy       (busy),
  .fmt_ok     (fmt_ok),
  .rx_full    (rx_full),
  .eng_done   (eng_done),
  .rx_overrun (rx_overrun),
  .sclk       (sclk),
  .idle_pol   (idle_pol)
);

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_fmt = '0;
  logic        cfg_loop = 1'b0;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_data = '0;
  logic        rx_rd = 1'b0;
  logic [31:0] stat;
  logic [15:0] rx_data;
  logic        rx_par_err;
  logic        rx_overrun;
  logic        sclk;
  logic        mosi;
  logic        miso_r = 1'b0;

  always #10 clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk        (clk),
    .rst        (rst),
    .cfg_fmt    (cfg_fmt),
    .cfg_loop   (cfg_loop),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .rx_rd      (rx_rd),
    .stat       (stat),
    .rx_data    (rx_data),
    .rx_par_err (rx_par_err),
    .rx_overrun (rx_overrun),
    .sclk       (sclk),
    .mosi       (mosi),
    .miso       (miso_r)
  );

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // serial monitor and slave model
  bit          m_cpol = 0;
  bit          m_pha0 = 1;
  logic        prev_sclk = 1'b0;
  int          ncap = 0;
  int          nlead = 0;
  logic [31:0] cap_v = '0;
  logic [31:0] sl_v = '0;
  int          sl_idx = 0;
  longint      lt [0:63];

  always @(posedge clk) begin
    #5;
    if (sclk !== prev_sclk) begin
      if (sclk != m_cpol) begin
        if (nlead < 64) lt[nlead] = cyc;
        nlead++;
        if (m_pha0) begin
          if (ncap < 32) cap_v[ncap] = mosi;
          ncap++;
        end else begin
          if (sl_idx < 32) miso_r = sl_v[sl_idx];
          sl_idx++;
        end
      end else begin
        if (!m_pha0) begin
          if (ncap < 32) cap_v[ncap] = mosi;
          ncap++;
        end else begin
          if (sl_idx < 32) miso_r = sl_v[sl_idx];
          sl_idx++;
        end
      end
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkfmt(input int pre, input int len, input bit cpol,
                                        input bit pha0, input bit lsb, input bit pen,
                                        input bit podd, input int gap);
    logic [31:0] w;
    w = '0;
    w[29:24] = 6'(gap);
    w[23] = podd;
    w[22] = pen;
    w[20] = lsb;
    w[17] = cpol;
    w[16] = pha0;
    w[15:8] = 8'(pre);
    w[4:0] = 5'(len);
    return w;
  endfunction

  function automatic logic [31:0] ref_seq(input logic [15:0] w, input int len,
                                          input bit lsb, input bit pen, input bit podd);
    logic [31:0] s;
    int ones;
    s = '0;
    ones = 0;
    for (int i = 0; i < len; i++) begin
      s[i] = lsb ? w[i] : w[len-1-i];
      if (w[i]) ones++;
    end
    if (pen) s[len] = podd ? ~ones[0] : ones[0];
    return s;
  endfunction

  task automatic clr_mon();
    ncap = 0;
    nlead = 0;
    cap_v = '0;
  endtask

  task automatic set_cfg(input logic [31:0] f, input bit loop);
    @(negedge clk);
    cfg_fmt = f;
    cfg_loop = loop;
    m_cpol = f[17];
    m_pha0 = f[16];
    repeat (3) @(negedge clk);
    clr_mon();
  endtask

  task automatic sl_load(input logic [31:0] seq, input bit pha0);
    sl_v = seq;
    if (pha0) begin
      miso_r = seq[0];
      sl_idx = 1;
    end else begin
      sl_idx = 0;
    end
  endtask

  task automatic send(input logic [15:0] w);
    int n;
    n = 0;
    while (stat[29] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    tx_wr = 1'b1;
    tx_data = w;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_rx();
    int n;
    n = 0;
    while (stat[31] && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_read();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(stat == 32'h8000_0000, "R1 status", stat, 32'h8000_0000);
    chk(rx_overrun == 1'b0, "R1 overrun", {31'b0, rx_overrun}, 32'h0);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 pins", {30'b0, sclk, mosi}, 32'h0);

    // R4: idle level follows polarity
    set_cfg(mkfmt(2, 8, 1, 1, 0, 0, 0, 0), 1);
    chk(sclk == 1'b1, "R4 idle high", {31'b0, sclk}, 32'h1);
    set_cfg(mkfmt(2, 8, 0, 1, 0, 0, 0, 0), 1);
    chk(sclk == 1'b0, "R4 idle low", {31'b0, sclk}, 32'h0);

    // R3 R4 R5 R8 R10: sweep of length, mode and parity
    for (int len = 2; len <= 16; len++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < 3; p++) begin
          bit cpol, pha0, lsb, pen, podd, loop;
          logic [15:0] mask, w, sw, expw;
          logic [31:0] eseq, cmask;
          int nb;
          cpol = m[0];
          pha0 = m[1];
          lsb = m[2];
          pen = (p != 0);
          podd = (p == 2);
          loop = ((len + m) % 2) == 1;
          mask = 16'((32'h1 << len) - 1);
          w = 16'(32'hA5C3 ^ (len * 32'h1F1) ^ (m * 32'h0707) ^ p) & mask;
          sw = (~w) & mask;
          nb = len + (pen ? 1 : 0);
          cmask = (32'h1 << nb) - 1;
          eseq = ref_seq(w, len, lsb, pen, podd);
          expw = loop ? w : sw;
          set_cfg(mkfmt(2, len, cpol, pha0, lsb, pen, podd, 0), loop);
          sl_load(ref_seq(sw, len, lsb, pen, podd), pha0);
          send(w);
          wait_rx();
          chk(rx_data == expw, "R3 R8 R10 rx word", {16'b0, rx_data}, {16'b0, expw});
          chk(rx_par_err == 1'b0, "R5 no parity error", {31'b0, rx_par_err}, 32'h0);
          chk((cap_v & cmask) == eseq, "R3 R4 R5 mosi sequence", cap_v & cmask, eseq);
          chk(nlead == nb, "R2 edge count", 32'(nlead), 32'(nb));
          do_read();
        end
      end
    end

    // R2: clock ratio sweep
    for (int pre = 2; pre <= 9; pre++) begin
      set_cfg(mkfmt(pre, 4, 0, 1, 0, 0, 0, 0), 1);
      send(16'h9);
      wait_rx();
      chk(lt[1] - lt[0] == longint'(pre + 1), "R2 bit period",
          32'(lt[1] - lt[0]), 32'(pre + 1));
      do_read();
    end

    // R2 R3 R7: refused formats hold the word, extra writes ignored
    set_cfg(mkfmt(1, 8, 0, 1, 0, 0, 0, 0), 1);
    send(16'h3C);
    repeat (40) @(negedge clk);
    chk(stat[29] == 1'b1, "R2 ratio below 3 held", {31'b0, stat[29]}, 32'h1);
    chk(nlead == 0, "R2 no clock on refusal", 32'(nlead), 32'h0);
    tx_wr = 1'b1;
    tx_data = 16'hC3;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(stat[29] == 1'b1, "R7 still full", {31'b0, stat[29]}, 32'h1);
    cfg_fmt = mkfmt(3, 1, 0, 1, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(stat[29] == 1'b1 && nlead == 0, "R3 length 1 held", {31'b0, stat[29]}, 32'h1);
    cfg_fmt = mkfmt(3, 17, 0, 1, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(stat[29] == 1'b1 && nlead == 0, "R3 length 17 held", {31'b0, stat[29]}, 32'h1);
    cfg_fmt = mkfmt(3, 8, 0, 1, 0, 0, 0, 0);
    wait_rx();
    chk(rx_data == 16'h3C, "R7 write while full ignored", {16'b0, rx_data}, 32'h3C);
    do_read();

    // R6: inter-word gap
    foreach (lt[k]) lt[k] = 0;
    for (int gi = 0; gi < 3; gi++) begin
      int g;
      g = (gi == 0) ? 0 : ((gi == 1) ? 7 : 63);
      repeat (80) @(negedge clk);
      set_cfg(mkfmt(3, 5, 0, 1, 0, 1, 0, g), 1);
      send(16'h15);
      send(16'h0A);
      wait_rx();
      do_read();
      wait_rx();
      chk(rx_data == 16'h0A, "R6 second word", {16'b0, rx_data}, 32'h0A);
      chk(lt[6] - lt[0] == longint'(6 * 4 + g + 1), "R6 word spacing",
          32'(lt[6] - lt[0]), 32'(6 * 4 + g + 1));
      do_read();
    end
    repeat (80) @(negedge clk);

    // R9: overrun
    set_cfg(mkfmt(2, 8, 0, 1, 0, 0, 0, 0), 1);
    send(16'h11);
    wait_rx();
    chk(rx_overrun == 1'b0, "R9 no overrun yet", {31'b0, rx_overrun}, 32'h0);
    send(16'h22);
    repeat (80) @(negedge clk);
    chk(rx_overrun == 1'b1, "R9 overrun set", {31'b0, rx_overrun}, 32'h1);
    chk(rx_data == 16'h22, "R9 newest word kept", {16'b0, rx_data}, 32'h22);
    do_read();
    chk(stat[31] == 1'b1, "R8 read empties", {31'b0, stat[31]}, 32'h1);
    chk(rx_overrun == 1'b0, "R9 read clears overrun", {31'b0, rx_overrun}, 32'h0);

    // R5 R8 R10: external line all ones, parity checked
    set_cfg(mkfmt(2, 8, 0, 1, 0, 1, 0, 0), 0);
    sl_load(32'hFFFF_FFFF, 1);
    send(16'h00);
    wait_rx();
    chk(rx_par_err == 1'b1, "R5 even parity mismatch", {31'b0, rx_par_err}, 32'h1);
    chk(rx_data == 16'h00FF, "R8 R10 upper bits zero", {16'b0, rx_data}, 32'hFF);
    do_read();
    set_cfg(mkfmt(2, 8, 0, 1, 0, 1, 1, 0), 0);
    sl_load(32'hFFFF_FFFF, 1);
    send(16'h00);
    wait_rx();
    chk(rx_par_err == 1'b0, "R5 odd parity match", {31'b0, rx_par_err}, 32'h0);
    do_read();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule